// File: doc/BRIEF.md
# Floating-Point Register Stack Unit

This block holds the eight-deep register file of a stack-style floating-point unit. Each slot stores one 64-bit IEEE-754 double and has a tag bit that marks it as in use. A 3-bit top pointer selects the current head of the stack. Operands are named relative to that pointer: ST(i) is physical slot (top + i) mod 8. Arithmetic, decode and memory access all sit outside. A result computed elsewhere comes back through the write data input.

One operation is issued per cycle with a valid strobe, a 3-bit operation code and an index. The operations are push, pop, write ST(i), exchange ST(0) with ST(i), free a tag, compare with an optional single or double pop, clear status and full initialise. The data of any ST(i) can be read combinationally through a separate read index, together with its tag. The top pointer, the tag vector, the 16-bit status word and the 16-bit control word are visible as outputs. The compare works directly on raw double bit patterns. It writes three condition bits into the status word and reports an unordered result when either operand is NaN.

Top module: `fpstk`

## Requirements
- R1: After reset the top pointer is 0, every tag is clear, every slot reads 0, the status word is 0 and the control word is 0x037F.
- R2: Operation code 0 (push) first decrements top modulo 8. It then stores the write data in the new head slot and sets that slot's tag.
- R3: Operation code 1 (pop) clears the tag of the current head slot and increments top modulo 8. Slot data is left unchanged.
- R4: The read port returns slot (top + read index) mod 8 and its tag combinationally. Operation code 2 stores the write data into ST(index) and sets its tag, with top unchanged.
- R5: Operation code 3 swaps the data of ST(0) and ST(index) in one cycle and sets both tags. With index 0 the data is unchanged.
- R6: Operation code 4 clears only the tag of ST(index). Data and top are unchanged.
- R7: Operation code 5 compares ST(0) with ST(index). It clears status bits 8, 9, 10 and 14, then sets bit 8 when ST(0) is smaller, bit 14 when they are equal and none when ST(0) is larger. The other status bits keep their value.
- R8: In a compare, any operand with exponent all ones and a nonzero fraction (NaN) sets bits 8, 10 and 14. +0 and -0 compare equal, and infinities order by sign.
- R9: The compare pop count input is applied after a compare: 0 leaves the stack alone, 1 pops once and 2 or 3 pops twice. Each pop clears the head tag and advances top.
- R10: Operation code 6 zeroes the whole status word.
- R11: Operation code 7 zeroes every slot, clears every tag, sets top to 0 and loads the control word with 0x037F. The status word keeps its value.
- R12: While the valid strobe is low the state does not change: top, tags, slot data, status and control all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe for the operation this cycle |
| op_code | input | 3 | Operation select (0 push … 7 initialise) |
| op_idx | input | 3 | Stack-relative index i for ST(i) |
| op_data | input | 64 | Write data for push and write ST(i) |
| cmp_pops | input | 2 | Pops after a compare (0, 1, 2 or more) |
| rd_idx | input | 3 | Stack-relative read index |
| rd_data | output | 64 | Data of ST(rd_idx) |
| rd_tag | output | 1 | Tag of ST(rd_idx) |
| top_ptr | output | 3 | Current top pointer |
| tag_bits | output | 8 | Tag per physical slot |
| status_word | output | 16 | Status word with condition bits |
| ctrl_word | output | 16 | Control word |

## Verification
A wrong top pointer is visible on top_ptr in the cycle after the faulty operation. It also shifts every ST(i) read, so a sweep of the read port exposes it right away. A corrupted slot or tag appears on rd_data and tag_bits in the next cycle, and a wrong magnitude or sign ordering in the comparator appears on the status word in the cycle after the compare. Because the bench sweeps all eight reads and the full state after every operation, each such fault is reported within one operation of the point where it occurs.

// File: rtl/fpstk.sv
`timescale 1ns/1ps
module fpstk (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [2:0]  op_idx,
  input  logic [63:0] op_data,
  input  logic [1:0]  cmp_pops,
  input  logic [2:0]  rd_idx,
  output logic [63:0] rd_data,
  output logic        rd_tag,
  output logic [2:0]  top_ptr,
  output logic [7:0]  tag_bits,
  output logic [15:0] status_word,
  output logic [15:0] ctrl_word
);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_WR = 3'd2, OP_XCH = 3'd3,
                         OP_FREE = 3'd4, OP_CMP = 3'd5, OP_CLR = 3'd6, OP_INIT = 3'd7;
  localparam logic [15:0] CW_INIT = 16'h037F;

  logic [63:0] slot [8];
  logic [2:0]  top;
  logic [7:0]  tag;
  logic [15:0] sw, cw;

  wire [2:0] pi  = top + op_idx;
  wire [2:0] tdn = top - 3'd1;
  wire [2:0] tp1 = top + 3'd1;
  wire [2:0] tp2 = top + 3'd2;
  wire [2:0] ri  = top + rd_idx;

  assign rd_data     = slot[ri];
  assign rd_tag      = tag[ri];
  assign top_ptr     = top;
  assign tag_bits    = tag;
  assign status_word = sw;
  assign ctrl_word   = cw;

  wire [63:0] ca = slot[top];
  wire [63:0] cb = slot[pi];
  wire a_nan = (ca[62:52] == 11'h7FF) && (ca[51:0] != 52'd0);
  wire b_nan = (cb[62:52] == 11'h7FF) && (cb[51:0] != 52'd0);
  wire unord = a_nan || b_nan;
  wire ceq   = ((ca[62:0] == 63'd0) && (cb[62:0] == 63'd0)) || (ca == cb);
  logic clt;
  always_comb begin
    if (ca[63] != cb[63]) clt = ca[63];
    else if (!ca[63])     clt = ca[62:0] < cb[62:0];
    else                  clt = ca[62:0] > cb[62:0];
  end
  wire c0 = unord || (!ceq && clt);
  wire c2 = unord;
  wire c3 = unord || ceq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) slot[k] <= '0;
      tag <= '0;
      top <= '0;
      sw  <= '0;
      cw  <= CW_INIT;
    end else if (op_valid) begin
      case (op_code)
        OP_PUSH: begin
          top       <= tdn;
          slot[tdn] <= op_data;
          tag[tdn]  <= 1'b1;
        end
        OP_POP: begin
          tag[top] <= 1'b0;
          top      <= tp1;
        end
        OP_WR: begin
          slot[pi] <= op_data;
          tag[pi]  <= 1'b1;
        end
        OP_XCH: begin
          slot[top] <= cb;
          slot[pi]  <= ca;
          tag[top]  <= 1'b1;
          tag[pi]   <= 1'b1;
        end
        OP_FREE: tag[pi] <= 1'b0;
        OP_CMP: begin
          sw <= {sw[15], c3, sw[13:11], c2, 1'b0, c0, sw[7:0]};
          if (cmp_pops == 2'd1) begin
            tag[top] <= 1'b0;
            top      <= tp1;
          end else if (cmp_pops >= 2'd2) begin
            tag[top] <= 1'b0;
            tag[tp1] <= 1'b0;
            top      <= tp2;
          end
        end
        OP_CLR: sw <= '0;
        default: begin
          for (int k = 0; k < 8; k++) slot[k] <= '0;
          tag <= '0;
          top <= '0;
          cw  <= CW_INIT;
        end
      endcase
    end
  end
endmodule

module fpstk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [1:0]  cmp_pops,
  input logic [2:0]  top_ptr,
  input logic [7:0]  tag_bits,
  input logic [15:0] status_word,
  input logic [15:0] ctrl_word
);
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd0 |=> top_ptr == 3'($past(top_ptr) - 3'd1) && tag_bits[top_ptr]);
  p_pop_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd1 |=> top_ptr == 3'($past(top_ptr) + 3'd1) && !tag_bits[$past(top_ptr)]);
  p_write_keeps_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd2 |=> top_ptr == $past(top_ptr));
  p_free_keeps_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd4 |=> top_ptr == $past(top_ptr) && $countones(tag_bits) <= $countones($past(tag_bits)));
  p_cmp_c1_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd5 |=> !status_word[9]);
  p_cmp_nopop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd5 && cmp_pops == 2'd0 |=> $stable(top_ptr) && $stable(tag_bits));
  p_clr_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd6 |=> status_word == 16'd0);
  p_init_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd7 |=> top_ptr == 3'd0 && tag_bits == 8'd0 && ctrl_word == 16'h037F);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(top_ptr) && $stable(tag_bits) && $stable(status_word) && $stable(ctrl_word));
endmodule

bind fpstk fpstk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .cmp_pops(cmp_pops),
  .top_ptr(top_ptr), .tag_bits(tag_bits), .status_word(status_word), .ctrl_word(ctrl_word)
);

// File: tb/fpstk_test.sv
`timescale 1ns/1ps
module fpstk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  op_idx = '0;
  logic [63:0] op_data = '0;
  logic [1:0]  cmp_pops = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_tag;
  logic [2:0]  top_ptr;
  logic [7:0]  tag_bits;
  logic [15:0] status_word, ctrl_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpstk uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_idx(op_idx),
    .op_data(op_data), .cmp_pops(cmp_pops), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_tag(rd_tag), .top_ptr(top_ptr), .tag_bits(tag_bits),
    .status_word(status_word), .ctrl_word(ctrl_word)
  );

  logic [63:0] m_slot [8];
  logic [7:0]  m_tag;
  logic [2:0]  m_top;
  logic [15:0] m_sw, m_cw;

  localparam logic [63:0] D_POS0 = 64'h0000_0000_0000_0000, D_NEG0 = 64'h8000_0000_0000_0000,
    D_ONE = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000,
    D_MONE = 64'hBFF0_0000_0000_0000, D_MTHREE = 64'hC008_0000_0000_0000,
    D_NAN = 64'h7FF8_0000_0000_0001, D_INF = 64'h7FF0_0000_0000_0000,
    D_MINF = 64'hFFF0_0000_0000_0000;

  function automatic bit m_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic logic [15:0] m_cmp(input logic [15:0] s, input logic [63:0] a, input logic [63:0] b);
    logic [15:0] r = s & ~16'h4700;
    if (m_nan(a) || m_nan(b)) r |= 16'h4500;
    else if ($bitstoreal(a) < $bitstoreal(b)) r |= 16'h0100;
    else if ($bitstoreal(a) == $bitstoreal(b)) r |= 16'h4000;
    return r;
  endfunction

  function automatic logic [63:0] pick();
    case ($urandom % 10)
      0: return D_POS0;
      1: return D_NEG0;
      2: return D_ONE;
      3: return D_MONE;
      4: return D_NAN;
      5: return D_INF;
      6: return D_MINF;
      7: return D_TWO;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic m_init();
    for (int k = 0; k < 8; k++) m_slot[k] = '0;
    m_tag = '0;
    m_top = '0;
    m_cw = 16'h037F;
  endtask

  task automatic m_pop();
    m_tag[m_top] = 1'b0;
    m_top = m_top + 3'd1;
  endtask

  task automatic model(input logic v, input logic [2:0] c, input logic [2:0] i,
                       input logic [63:0] d, input logic [1:0] p);
    logic [2:0] s = m_top + i;
    logic [63:0] t;
    if (!v) return;
    case (c)
      3'd0: begin m_top = m_top - 3'd1; m_slot[m_top] = d; m_tag[m_top] = 1'b1; end
      3'd1: m_pop();
      3'd2: begin m_slot[s] = d; m_tag[s] = 1'b1; end
      3'd3: begin
        t = m_slot[m_top]; m_slot[m_top] = m_slot[s]; m_slot[s] = t;
        m_tag[m_top] = 1'b1; m_tag[s] = 1'b1;
      end
      3'd4: m_tag[s] = 1'b0;
      3'd5: begin
        m_sw = m_cmp(m_sw, m_slot[m_top], m_slot[s]);
        if (p >= 2'd1) m_pop();
        if (p >= 2'd2) m_pop();
      end
      3'd6: m_sw = '0;
      default: m_init();
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic verify(input string req);
    chk(top_ptr == m_top, req, "top", 64'(top_ptr), 64'(m_top));
    chk(tag_bits == m_tag, req, "tags", 64'(tag_bits), 64'(m_tag));
    chk(status_word == m_sw, req, "status", 64'(status_word), 64'(m_sw));
    chk(ctrl_word == m_cw, req, "control", 64'(ctrl_word), 64'(m_cw));
    for (int k = 0; k < 8; k++) begin
      rd_idx = 3'(k);
      #0.1;
      chk(rd_data == m_slot[3'(m_top + 3'(k))], req, "ST data", rd_data, m_slot[3'(m_top + 3'(k))]);
      chk(rd_tag == m_tag[3'(m_top + 3'(k))], req, "ST tag", 64'(rd_tag), 64'(m_tag[3'(m_top + 3'(k))]));
    end
  endtask

  task automatic run(input string req, input logic v, input logic [2:0] c, input logic [2:0] i,
                     input logic [63:0] d, input logic [1:0] p);
    op_valid = v; op_code = c; op_idx = i; op_data = d; cmp_pops = p;
    model(v, c, i, d, p);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    verify(req);
  endtask

  task automatic cmp_case(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [15:0] exp_cc);
    run("R2", 1'b1, 3'd0, 3'd0, b, 2'd0);
    run("R2", 1'b1, 3'd0, 3'd0, a, 2'd0);
    run(req, 1'b1, 3'd5, 3'd1, '0, 2'd0);
    chk((status_word & 16'h4700) == exp_cc, req, "condition bits", 64'(status_word & 16'h4700), 64'(exp_cc));
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_init();
    m_sw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    verify("R1");
    chk(ctrl_word == 16'h037F, "R1", "control after reset", 64'(ctrl_word), 64'h037F);

    run("R2", 1'b1, 3'd0, 3'd0, D_ONE, 2'd0);
    chk(top_ptr == 3'd7, "R2", "push wraps top", 64'(top_ptr), 64'd7);
    run("R2", 1'b1, 3'd0, 3'd0, D_TWO, 2'd0);
    run("R2", 1'b1, 3'd0, 3'd0, D_MTHREE, 2'd0);
    run("R4", 1'b1, 3'd2, 3'd2, D_INF, 2'd0);
    run("R5", 1'b1, 3'd3, 3'd2, '0, 2'd0);
    run("R5", 1'b1, 3'd3, 3'd0, '0, 2'd0);
    run("R6", 1'b1, 3'd4, 3'd1, '0, 2'd0);
    run("R3", 1'b1, 3'd1, 3'd0, '0, 2'd0);
    run("R12", 1'b0, 3'd7, 3'd3, D_NAN, 2'd2);
    run("R12", 1'b0, 3'd0, 3'd1, D_ONE, 2'd0);

    cmp_case("R7", D_TWO, D_ONE, 16'h0000);
    cmp_case("R7", D_MONE, D_ONE, 16'h0100);
    cmp_case("R7", D_TWO, D_TWO, 16'h4000);
    cmp_case("R7", D_MTHREE, D_MONE, 16'h0100);
    cmp_case("R8", D_POS0, D_NEG0, 16'h4000);
    cmp_case("R8", D_NAN, D_ONE, 16'h4500);
    cmp_case("R8", D_ONE, D_NAN, 16'h4500);
    cmp_case("R8", D_MINF, D_INF, 16'h0100);
    cmp_case("R8", D_INF, D_TWO, 16'h0000);

    run("R2", 1'b1, 3'd0, 3'd0, D_ONE, 2'd0);
    run("R2", 1'b1, 3'd0, 3'd0, D_MONE, 2'd0);
    run("R9", 1'b1, 3'd5, 3'd1, '0, 2'd1);
    run("R9", 1'b1, 3'd5, 3'd1, '0, 2'd2);
    run("R9", 1'b1, 3'd5, 3'd1, '0, 2'd3);
    run("R10", 1'b1, 3'd6, 3'd0, '0, 2'd0);
    chk(status_word == 16'd0, "R10", "status cleared", 64'(status_word), 64'd0);
    run("R11", 1'b1, 3'd7, 3'd0, '0, 2'd0);
    for (int n = 0; n < 9; n++) run("R2", 1'b1, 3'd0, 3'd0, pick(), 2'd0);
    run("R11", 1'b1, 3'd7, 3'd0, '0, 2'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] c = 3'($urandom % 8);
      logic v = ($urandom % 8) != 0;
      string req;
      if (c == 3'd7 && ($urandom % 4) != 0) c = 3'd0;
      case (c)
        3'd0: req = "R2"; 3'd1: req = "R3"; 3'd2: req = "R4"; 3'd3: req = "R5";
        3'd4: req = "R6"; 3'd5: req = "R7"; 3'd6: req = "R10"; default: req = "R11";
      endcase
      if (!v) req = "R12";
      run(req, v, c, 3'($urandom % 8), pick(), 2'($urandom % 4));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule